// File: doc/BRIEF.md
# SAR ADC Conversion and Serial Port Controller

This block is the digital half of a multiplexed successive-approximation converter. A rising edge on the combined chip-select/convert input launches a conversion. The controller then resolves the result one bit per clock, most significant bit first. Each cycle it drives a trial code to an external DAC and reads back a single comparator decision. When the last bit is settled, the word is copied into a readout latch, which stays unchanged until the next conversion finishes.

While no conversion is running and chip select is low, a serial port does two jobs at once. It shifts the latched result out, most significant bit first, and it shifts in a seven-bit configuration word. The word is applied on the next rising edge of chip select. It selects the positive and negative analog inputs, unipolar or bipolar coding, and a sleep request. A programmable acquisition time must pass after reset, or after the end of a conversion, before a new conversion may begin. The comparator, DAC, reference and analog multiplexer lie outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset: busy, done, sdo and dac_code are 0, the readout latch holds 0, sleep is 0, and the selection is positive channel 0, negative channel 1, neg_gnd 0, unipolar 0.
- R2: A conversion starts at the clock edge where cs_conv is sampled high after being sampled low, provided no conversion is running and the acquisition time has passed; busy is high from the next cycle.
- R3: While busy, edges on cs_conv are ignored, including an edge sampled at the final bit decision; busy stays high for exactly RES_W cycles.
- R4: In the k-th busy cycle (k from 0), dac_code holds the bits already decided, plus a trial 1 at bit RES_W-1-k, with all lower bits 0. The trial bit is kept when cmp is 1. While not busy, dac_code is 0.
- R5: At the final decision the word is loaded into the readout latch. done is high for exactly one cycle, the cycle in which busy first reads 0.
- R6: A convert edge is honoured only if ACQ_CYC or more idle cycles have passed since reset or since busy fell; an earlier edge starts nothing.
- R7: A falling cs_conv while idle loads the readout latch into the output shifter. sdo shows bit RES_W-1 from the next cycle and moves one bit down after each falling sclk edge that is sampled while cs_conv is low and the block is idle.
- R8: sdi is shifted in on rising sclk edges while cs_conv is low and idle. The last seven bits form the word, first bit received = bit 6. The word is applied at the next accepted rising cs_conv only if at least seven bits arrived; otherwise the old selection is kept. The selection outputs change at no other time.
- R9: Word bit 6 = 1 (single-ended): pos_ch = {bit4, bit3, bit5}. If bit 2 = 1, neg_ch = 7 and neg_gnd = 0; otherwise neg_gnd = 1 and neg_ch = 0.
- R10: Word bit 6 = 0 (differential): pos_ch = {bit4, bit3, bit5} and neg_ch = {bit4, bit3, !bit5}, neg_gnd = 0, and bit 2 has no effect. In both modes unipolar = bit 1.
- R11: At each accepted rising cs_conv, sleep takes bit 0 of a complete new word, or 0 if no complete word arrived; sleep changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_conv | input | 1 | Chip select (low) and convert start (rising edge) |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial configuration data in |
| cmp | input | 1 | Comparator decision: input at or above the trial level |
| sdo | output | 1 | Serial result data out |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result latch updates |
| dac_code | output | RES_W | Trial code to the DAC |
| pos_ch | output | 3 | Positive input channel |
| neg_ch | output | 3 | Negative input channel when neg_gnd is 0 |
| neg_gnd | output | 1 | Negative input tied to ground |
| unipolar | output | 1 | Unipolar coding selected |
| sleep | output | 1 | Sleep requested |

## Verification
The sharpest collision is a convert edge that lands on the same clock edge as the final bit decision. At that moment the result latch updates, busy falls and done rises. The bench raises cs_conv in the last busy cycle of each conversion. It then confirms that no second conversion starts, that done pulses once, and that the latch holds the resolved value. A second overlap is the rising cs_conv that both applies a new word and launches a conversion. The bench judges this against a behavioural model that updates the selection and starts busy from the same sampled edge.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  localparam int CFG_W = 7;

  // configuration word without the sleep bit, field order = shift-in order
  typedef struct packed {
    logic single_end;
    logic odd_pol;
    logic addr_hi;
    logic addr_lo;
    logic ref_ch7;
    logic uni;
  } mux_cfg_t;
endpackage

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = $clog2(RES_W);

  logic [RES_W-1:0] sar_q, sar_d, res_d, trial_bit;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_d, done_d;

  always_comb begin
    trial_bit        = '0;
    trial_bit[idx_q] = 1'b1;
    sar_d  = sar_q;
    idx_d  = idx_q;
    busy_d = busy;
    done_d = 1'b0;
    res_d  = result;
    if (busy) begin
      if (cmp) sar_d = sar_q | trial_bit;
      if (idx_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_d  = sar_d;
      end else begin
        idx_d = idx_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      sar_d  = '0;
      idx_d  = IDX_W'(RES_W - 1);
    end
  end

  assign dac_code = busy ? (sar_q | trial_bit) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      idx_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      sar_q  <= sar_d;
      idx_q  <= idx_d;
      busy   <= busy_d;
      done   <= done_d;
      result <= res_d;
    end
  end
endmodule

// File: rtl/sar_serial.sv
module sar_serial #(
  parameter int RES_W = 16,
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift_en,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [RES_W-1:0] load_word,
  output logic             sdo,
  output logic [CFG_W-1:0] rx_word,
  output logic             rx_full
);
  localparam int CNT_W = $clog2(CFG_W + 1);

  logic             sclk_q, sclk_rise, sclk_fall;
  logic [RES_W-1:0] tx_q, tx_d;
  logic [CFG_W-1:0] rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign rx_full   = (cnt_q == CNT_W'(CFG_W));
  assign sdo       = tx_q[RES_W-1];

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_word;
    cnt_d = cnt_q;
    if (load) begin
      tx_d  = load_word;
      cnt_d = '0;
    end else if (shift_en) begin
      if (sclk_rise) begin
        rx_d = {rx_word[CFG_W-2:0], sdi};
        if (!rx_full) cnt_d = cnt_q + 1'b1;
      end
      if (sclk_fall) tx_d = tx_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      tx_q    <= '0;
      rx_word <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q  <= sclk;
      tx_q    <= tx_d;
      rx_word <= rx_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sar_mux_decode.sv
module sar_mux_decode
  import sar_ctrl_pkg::*;
(
  input  mux_cfg_t   cfg,
  output logic [2:0] pos_ch,
  output logic [2:0] neg_ch,
  output logic       neg_gnd,
  output logic       unipolar
);
  always_comb begin
    pos_ch   = {cfg.addr_hi, cfg.addr_lo, cfg.odd_pol};
    unipolar = cfg.uni;
    if (cfg.single_end) begin
      neg_gnd = ~cfg.ref_ch7;
      neg_ch  = cfg.ref_ch7 ? 3'd7 : 3'd0;
    end else begin
      neg_gnd = 1'b0;
      neg_ch  = {cfg.addr_hi, cfg.addr_lo, ~cfg.odd_pol};
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int RES_W   = 16,
  parameter int ACQ_CYC = 252
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_conv,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             cmp,
  output logic             sdo,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] dac_code,
  output logic [2:0]       pos_ch,
  output logic [2:0]       neg_ch,
  output logic             neg_gnd,
  output logic             unipolar,
  output logic             sleep
);
  localparam int ACQ_W = $clog2(ACQ_CYC + 1);

  logic             cs_q, cs_rise, cs_fall, accept, acq_ok, start;
  logic [ACQ_W-1:0] acq_q, acq_d;
  mux_cfg_t         cfg_q, cfg_d;
  logic             sleep_d;
  logic [CFG_W-1:0] rx_word;
  logic             rx_full;
  logic [RES_W-1:0] result;

  assign cs_rise = cs_conv & ~cs_q;
  assign cs_fall = ~cs_conv & cs_q;
  assign accept  = cs_rise & ~busy;
  assign acq_ok  = (acq_q == ACQ_W'(ACQ_CYC));
  assign start   = accept & acq_ok;

  always_comb begin
    if (busy)        acq_d = '0;
    else if (acq_ok) acq_d = acq_q;
    else             acq_d = acq_q + 1'b1;
    cfg_d   = cfg_q;
    sleep_d = sleep;
    if (accept) begin
      if (rx_full) cfg_d = mux_cfg_t'(rx_word[CFG_W-1:1]);
      sleep_d = rx_full & rx_word[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      acq_q <= '0;
      cfg_q <= '0;
      sleep <= 1'b0;
    end else begin
      cs_q  <= cs_conv;
      acq_q <= acq_d;
      cfg_q <= cfg_d;
      sleep <= sleep_d;
    end
  end

  sar_bit_engine #(.RES_W(RES_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmp      (cmp),
    .busy     (busy),
    .done     (done),
    .dac_code (dac_code),
    .result   (result)
  );

  sar_serial #(.RES_W(RES_W), .CFG_W(CFG_W)) u_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cs_fall & ~busy),
    .shift_en  (~busy & ~cs_conv),
    .sclk      (sclk),
    .sdi       (sdi),
    .load_word (result),
    .sdo       (sdo),
    .rx_word   (rx_word),
    .rx_full   (rx_full)
  );

  sar_mux_decode u_decode (
    .cfg      (cfg_q),
    .pos_ch   (pos_ch),
    .neg_ch   (neg_ch),
    .neg_gnd  (neg_gnd),
    .unipolar (unipolar)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_conv,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] dac_code,
  input logic [2:0]       pos_ch,
  input logic [2:0]       neg_ch,
  input logic             neg_gnd,
  input logic             unipolar,
  input logic             sleep
);
  logic [7:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 8'd1 : 8'd0;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_conv));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == 8'(RES_W));

  p_busy_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < 8'(RES_W));

  p_dac_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == (RES_W'(1) << (RES_W - 1)));

  p_dac_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_code == '0);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_conv |=> $stable({pos_ch, neg_ch, neg_gnd, unipolar}));

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_conv |=> $stable(sleep));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_conv  (cs_conv),
  .busy     (busy),
  .done     (done),
  .dac_code (dac_code),
  .pos_ch   (pos_ch),
  .neg_ch   (neg_ch),
  .neg_gnd  (neg_gnd),
  .unipolar (unipolar),
  .sleep    (sleep)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  localparam int RES_W   = 16;
  localparam int ACQ_CYC = 252;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [RES_W-1:0] vin = '0;
  logic sdo, busy, done, neg_gnd, unipolar, sleep;
  logic [RES_W-1:0] dac_code;
  logic [2:0] pos_ch, neg_ch;
  logic cmp;

  assign cmp = (vin >= dac_code);

  always #4 clk = ~clk;

  sar_conv_ctrl #(.RES_W(RES_W), .ACQ_CYC(ACQ_CYC)) u_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_conv(cs), .sclk(sclk), .sdi(sdi), .cmp(cmp),
    .sdo(sdo), .busy(busy), .done(done), .dac_code(dac_code),
    .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_gnd(neg_gnd),
    .unipolar(unipolar), .sleep(sleep)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done, m_sleep, m_csp, m_sclkp, m_on;
  int m_bit, m_acq, m_rxcnt;
  logic [RES_W-1:0] m_word, m_result, m_tx, m_trial;
  logic [6:0] m_rx, m_cfg;
  bit m_rise, m_fall, m_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_sleep = 0; m_csp = 1; m_sclkp = 0;
      m_bit = 0; m_acq = 0; m_rxcnt = 0;
      m_word = '0; m_result = '0; m_tx = '0; m_rx = '0; m_cfg = '0;
    end else begin
      m_rise = cs && !m_csp;
      m_fall = !cs && m_csp;
      m_done = 0;
      if (m_busy) begin
        m_acq = 0;
        m_trial = m_word | (RES_W'(1) << m_bit);
        if (vin >= m_trial) m_word = m_trial;
        if (m_bit == 0) begin
          m_busy = 0; m_done = 1; m_result = m_word;
        end else m_bit--;
      end else begin
        m_ok = (m_acq == ACQ_CYC);
        if (m_acq < ACQ_CYC) m_acq++;
        if (m_rise) begin
          if (m_rxcnt >= 7) m_cfg = m_rx;
          m_sleep = (m_rxcnt >= 7) && m_rx[0];
          if (m_ok) begin m_busy = 1; m_bit = RES_W - 1; m_word = '0; end
        end
        if (m_fall) begin
          m_tx = m_result; m_rxcnt = 0;
        end else if (!cs) begin
          if (sclk && !m_sclkp) begin
            m_rx = {m_rx[5:0], sdi};
            if (m_rxcnt < 7) m_rxcnt++;
          end
          if (!sclk && m_sclkp) m_tx = m_tx << 1;
        end
      end
      m_csp = cs;
      m_sclkp = sclk;
    end
  end

  task automatic exp_sel(input logic [6:0] w, output logic [2:0] p, output logic [2:0] n,
                         output logic g, output logic u);
    p = {w[4], w[3], w[5]};
    u = w[1];
    if (w[6]) begin
      g = !w[2];
      n = w[2] ? 3'd7 : 3'd0;
    end else begin
      g = 1'b0;
      n = {w[4], w[3], !w[5]};
    end
  endtask

  always @(negedge clk) begin
    if (m_on) begin
      logic [2:0] ep, en;
      logic eg, eu;
      exp_sel(m_cfg, ep, en, eg, eu);
      chk("R2 busy vs model", 32'(busy), 32'(m_busy));
      chk("R5 done vs model", 32'(done), 32'(m_done));
      chk("R4 dac_code vs model", 32'(dac_code),
          m_busy ? 32'(m_word | (RES_W'(1) << m_bit)) : 32'd0);
      chk("R7 sdo vs model", 32'(sdo), 32'(m_tx[RES_W-1]));
      chk("R8 selection vs model", {24'd0, pos_ch, neg_ch, neg_gnd, unipolar},
          {24'd0, ep, en, eg, eu});
      chk("R11 sleep vs model", 32'(sleep), 32'(m_sleep));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nclk serial pulses; the last seven input bits carry w, bit 6 first
  task automatic xfer(input logic [6:0] w, input int nclk, output logic [RES_W-1:0] rd);
    rd = '0;
    cs = 1'b0;
    tick(2);
    for (int i = 0; i < nclk; i++) begin
      int idx;
      idx = nclk - 1 - i;
      if (i < RES_W) rd[RES_W-1-i] = sdo;
      sdi = (idx < 7) ? w[idx] : 1'b0;
      tick(1); sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    cs = 1'b1;
  endtask

  // wait acquisition, transfer word, convert value v; returns previous result
  task automatic conv(input logic [RES_W-1:0] v, input logic [6:0] w,
                      output logic [RES_W-1:0] prev);
    int cnt;
    tick(ACQ_CYC + 4);
    vin = v;
    xfer(w, RES_W, prev);
    tick(1);
    chk("R2 busy after convert edge", 32'(busy), 32'd1);
    chk("R4 first trial is MSB", 32'(dac_code), 32'(RES_W'(1) << (RES_W - 1)));
    cnt = 0;
    while (busy === 1'b1 && cnt < 100) begin
      cnt++;
      if (cnt == 4) cs = 1'b0;
      if (cnt == RES_W) cs = 1'b1;   // edge sampled at the final decision
      tick(1);
    end
    chk("R3 busy length", 32'(cnt), 32'(RES_W));
    chk("R5 done with busy fall", 32'(done), 32'd1);
    tick(3);
    chk("R3 late edge ignored", 32'(busy), 32'd0);
    chk("R5 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    logic [RES_W-1:0] rd;
    tick(3);
    chk("R1 busy reset", 32'(busy), 32'd0);
    chk("R1 done reset", 32'(done), 32'd0);
    chk("R1 sdo reset", 32'(sdo), 32'd0);
    chk("R1 dac reset", 32'(dac_code), 32'd0);
    chk("R1 selection reset", {26'd0, pos_ch, neg_ch}, {26'd0, 3'd0, 3'd1});
    chk("R1 gnd/uni/sleep reset", {29'd0, neg_gnd, unipolar, sleep}, 32'd0);
    rst_n = 1'b1;
    m_on = 1'b1;

    conv(16'h1234, 7'b1110100, rd);
    chk("R7 readout of reset latch", 32'(rd), 32'd0);
    chk("R9 single-ended, neg ch7", {25'd0, pos_ch, neg_ch, neg_gnd}, {25'd0, 3'd5, 3'd7, 1'b0});

    conv(16'hFFFF, 7'b1001010, rd);
    chk("R7 readout 1234", 32'(rd), 32'h1234);
    chk("R9 single-ended, ground", {25'd0, pos_ch, neg_ch, neg_gnd}, {25'd0, 3'd2, 3'd0, 1'b1});
    chk("R10 unipolar bit", 32'(unipolar), 32'd1);

    conv(16'h0000, 7'b0111100, rd);
    chk("R7 readout FFFF", 32'(rd), 32'hFFFF);
    chk("R10 differential swapped, ch7 bit ignored", {25'd0, pos_ch, neg_ch, neg_gnd},
        {25'd0, 3'd7, 3'd6, 1'b0});

    conv(16'h8000, 7'b0001001, rd);
    chk("R7 readout 0000", 32'(rd), 32'h0000);
    chk("R10 differential pair", {26'd0, pos_ch, neg_ch}, {26'd0, 3'd2, 3'd3});
    chk("R11 sleep requested", 32'(sleep), 32'd1);

    // early edge right after the conversion
    cs = 1'b0; tick(2); cs = 1'b1; tick(2);
    chk("R6 early edge starts nothing", 32'(busy), 32'd0);
    chk("R11 sleep cleared by edge", 32'(sleep), 32'd0);

    // short word: five pulses only, selection kept
    tick(ACQ_CYC + 4);
    vin = 16'h0001;
    xfer(7'b1111111, 5, rd);
    tick(1);
    chk("R2 convert after short word", 32'(busy), 32'd1);
    chk("R8 short word keeps selection", {26'd0, pos_ch, neg_ch}, {26'd0, 3'd2, 3'd3});
    tick(RES_W + 2);

    conv(16'h7FFF, 7'b0000000, rd);
    chk("R7 readout 0001", 32'(rd), 32'h0001);
    conv(16'h0000, 7'b0000000, rd);
    chk("R5 result latched 7FFF", 32'(rd), 32'h7FFF);

    tick(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule